// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block collects interrupt requests from up to eight peripheral sources into one pending register and drives a single level interrupt toward an upstream router. Peripherals raise and retire their requests with one-cycle set and clear pulse vectors. Software controls which pending requests reach the output through an enable mask, and retires a serviced request by writing its index as an end-of-interrupt command.

Software reaches the block through a byte-wide register port with four addresses. Address 0 is the mask of the active bank. It is written as a mask byte, where a 1 blocks the source, and is held internally as an enable set. Address 1 reads the pending register and takes end-of-interrupt writes. Address 2 is the mask of a cascaded second bank, which is stored only. Address 3 is that second bank's request register, which always reads zero. A wide read at address 1 returns the pending register zero-extended to 64 bits. Reads are combinational from the current state. Writes take effect at the next clock edge.

Top module: `irq_agg_top`

## Requirements
- R1: A write of byte B to address 0 stores the enable set ~B; a following byte read of address 0 returns B, that is, the complement of the enable set.
- R2: The output `irq` is a registered level: in the cycle after any edge, it is 1 exactly when (pending AND enable) is non-zero.
- R3: A mask write re-evaluates `irq` at the same edge that stores the mask, raising it when enabled requests now exist and lowering it when none remain.
- R4: A write of byte B to address 1 clears pending bit B[3:0]; when B[3:0] is 8 or more, no pending bit changes.
- R5: Each bit set in `src_set` ORs into the pending register at the next edge. Each bit set in `src_clr` is removed from it, and `irq` drops if no enabled request remains.
- R6: When set and clear, or set and end-of-interrupt, hit the same bit in one cycle, the bit ends up pending.
- R7: A write of byte B to address 2 stores B uninverted and reads back as B. A byte read of address 3 returns 0x00, writes to address 3 change nothing, and neither address ever affects `irq` or the pending register.
- R8: With `reg_wide` high, a read of address 1 returns the pending register zero-extended to 64 bits, and a read of any other address returns zero. Byte reads are zero-extended to 64 bits.
- R9: After reset the pending register is 0x00, all sources are masked (address 0 reads 0xFF), the second bank's mask reads 0x00, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 8 | Per-source request set pulses |
| src_clr | input | 8 | Per-source request clear pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | Read is a 64-bit access |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational |
| irq | output | 1 | Level interrupt toward the router |

## Verification
The hardest cases to reach are the same-cycle collisions. In these, a set pulse meets a clear pulse or an end-of-interrupt write on the same bit, or a mask write lands while a set pulse changes the pending register. The bench drives these coincidences directly on chosen bits. It then runs a long stretch of random pulses, random writes and random addresses, so that collisions on every bit and end-of-interrupt indices above 7 also occur. A behavioural model is compared against `irq` and the read data on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int IDX_W = 4;

    typedef enum logic [1:0] {
        A_MASK0 = 2'd0,
        A_PEND0 = 2'd1,
        A_MASK1 = 2'd2,
        A_PEND1 = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode #(
    parameter int SRC_W = 8
) (
    input  logic                            wr_i,
    input  logic [1:0]                      addr_i,
    input  logic [irq_agg_pkg::IDX_W-1:0]   idx_i,
    output logic                            mask0_we_o,
    output logic                            mask1_we_o,
    output logic [SRC_W-1:0]                eoi_vec_o
);
    import irq_agg_pkg::*;

    logic eoi_hit;

    always_comb begin
        mask0_we_o = wr_i && (addr_i == A_MASK0);
        mask1_we_o = wr_i && (addr_i == A_MASK1);
        eoi_hit    = wr_i && (addr_i == A_PEND0);
    end

    // One-hot clear vector; indices at or above SRC_W match no bit.
    for (genvar g = 0; g < SRC_W; g++) begin : g_eoi
        assign eoi_vec_o[g] = eoi_hit && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_i,
    input  logic [SRC_W-1:0] clr_i,
    input  logic [SRC_W-1:0] eoi_i,
    input  logic             mask_we_i,
    input  logic [SRC_W-1:0] mask_wdata_i,
    output logic [SRC_W-1:0] pend_o,
    output logic [SRC_W-1:0] en_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [SRC_W-1:0] pend;
        logic [SRC_W-1:0] en;
        logic             irq;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // Set is ORed last, so it wins over clear and end-of-interrupt.
        st_d.pend = (st_q.pend & ~clr_i & ~eoi_i) | set_i;
        if (mask_we_i) begin
            st_d.en = ~mask_wdata_i;
        end
        st_d.irq  = |(st_d.pend & st_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;

    assert_mask_inverted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (en_o == ~$past(mask_wdata_i)));

    assert_irq_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(pend_o & en_o)));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_agg_cascade.sv
module irq_agg_cascade #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o
);
    logic [DATA_W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = we_i ? wdata_i : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

    assert_cascade_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
    parameter int SRC_W  = 8,
    parameter int DATA_W = 8,
    parameter int WIDE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_set,
    input  logic [SRC_W-1:0]  src_clr,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [WIDE_W-1:0] reg_rdata,
    output logic              irq
);
    import irq_agg_pkg::*;

    logic              mask0_we, mask1_we;
    logic [SRC_W-1:0]  eoi_vec, pend, en;
    logic [DATA_W-1:0] mask1;
    logic [DATA_W-1:0] byte_rd;

    irq_agg_decode #(.SRC_W(SRC_W)) u_dec (
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .idx_i      (reg_wdata[IDX_W-1:0]),
        .mask0_we_o (mask0_we),
        .mask1_we_o (mask1_we),
        .eoi_vec_o  (eoi_vec)
    );

    irq_agg_bank #(.SRC_W(SRC_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (src_set),
        .clr_i        (src_clr),
        .eoi_i        (eoi_vec),
        .mask_we_i    (mask0_we),
        .mask_wdata_i (reg_wdata[SRC_W-1:0]),
        .pend_o       (pend),
        .en_o         (en),
        .irq_o        (irq)
    );

    irq_agg_cascade #(.DATA_W(DATA_W)) u_casc (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask1_we),
        .wdata_i (reg_wdata),
        .mask_o  (mask1)
    );

    always_comb begin
        byte_rd = '0;
        unique case (reg_addr)
            A_MASK0: byte_rd = DATA_W'(~en);
            A_PEND0: byte_rd = DATA_W'(pend);
            A_MASK1: byte_rd = mask1;
            default: byte_rd = '0;
        endcase
        if (reg_wide) begin
            reg_rdata = (reg_addr == A_PEND0) ? WIDE_W'(pend) : '0;
        end else begin
            reg_rdata = WIDE_W'(byte_rd);
        end
    end

    assert_cascade_req_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wide && reg_addr == A_PEND1) |-> (reg_rdata == '0));

    assert_wide_zero_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wide |-> ((reg_rdata >> SRC_W) == '0));
endmodule

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  src_set = '0, src_clr = '0;
    logic        reg_wr = 0, reg_wide = 0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_pend = '0, m_en = '0, m_casc = '0;
    logic       m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_top u0 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .reg_wr(reg_wr), .reg_wide(reg_wide), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [63:0] model_read(logic wide, logic [1:0] a);
        if (wide) return (a == 2'd1) ? {56'd0, m_pend} : 64'd0;
        case (a)
            2'd0: return {56'd0, ~m_en};
            2'd1: return {56'd0, m_pend};
            2'd2: return {56'd0, m_casc};
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compare outputs, then advance the model.
    task automatic cyc(string req, logic [7:0] s, logic [7:0] c, logic wr,
                       logic [1:0] a, logic [7:0] d, logic wide);
        logic [7:0] eoi;
        @(negedge clk);
        src_set = s; src_clr = c; reg_wr = wr; reg_addr = a;
        reg_wdata = d; reg_wide = wide;
        #1;
        check({req, " irq"}, {63'd0, irq}, {63'd0, m_irq});
        check({req, " rdata"}, reg_rdata, model_read(wide, a));
        eoi = (wr && a == 2'd1 && d[3:0] < 4'd8) ? (8'd1 << d[3:0]) : 8'd0;
        @(posedge clk);
        m_pend = (m_pend & ~c & ~eoi) | s;
        if (wr && a == 2'd0) m_en = ~d;
        if (wr && a == 2'd2) m_casc = d;
        m_irq = |(m_pend & m_en);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9 irq", {63'd0, irq}, 64'd0);
        check("R9 mask0", reg_rdata, 64'h00000000000000ff);
        reg_addr = 2'd1; #1;
        check("R9 pend", reg_rdata, 64'd0);
        reg_addr = 2'd2; #1;
        check("R9 mask1", reg_rdata, 64'd0);
        rst_n = 1;

        // R5 set while all masked: irq stays low
        cyc("R5 set", 8'h05, 0, 0, 2'd1, 0, 0);
        cyc("R5 pend", 0, 0, 0, 2'd1, 0, 0);
        // R1 R3 unmask bit0 raises irq
        cyc("R3 unmask", 0, 0, 1, 2'd0, 8'hFE, 0);
        cyc("R1 readback", 0, 0, 0, 2'd0, 0, 0);
        cyc("R3 remask", 0, 0, 1, 2'd0, 8'hFF, 0);
        cyc("R3 low", 0, 0, 1, 2'd0, 8'h00, 0);
        // R4 end-of-interrupt
        cyc("R4 eoi0", 0, 0, 1, 2'd1, 8'h10, 0);
        cyc("R4 eoi9", 0, 0, 1, 2'd1, 8'h09, 0);
        cyc("R4 eoi2", 0, 0, 1, 2'd1, 8'h02, 0);
        cyc("R4 empty", 0, 0, 0, 2'd1, 0, 0);
        // R6 collisions
        cyc("R6 set+clr", 8'h08, 8'h08, 0, 2'd1, 0, 0);
        cyc("R6 set+eoi", 8'h40, 0, 1, 2'd1, 8'h06, 0);
        cyc("R6 read", 0, 0, 0, 2'd1, 0, 0);
        // R5 clear drops irq
        cyc("R5 clr", 0, 8'hFF, 0, 2'd1, 0, 0);
        cyc("R5 after", 0, 0, 0, 2'd1, 0, 0);
        // R7 cascade bank
        cyc("R7 wr mask1", 8'h01, 0, 1, 2'd2, 8'h5A, 0);
        cyc("R7 rd mask1", 0, 0, 1, 2'd3, 8'hFF, 0);
        cyc("R7 rd req1", 0, 0, 0, 2'd3, 0, 0);
        cyc("R7 pend kept", 0, 0, 0, 2'd1, 0, 0);
        // R8 wide reads
        cyc("R8 wide pend", 8'h80, 0, 0, 2'd1, 0, 1);
        cyc("R8 wide pend2", 0, 0, 0, 2'd1, 0, 1);
        cyc("R8 wide mask", 0, 0, 0, 2'd0, 0, 1);
        cyc("R8 wide casc", 0, 0, 0, 2'd2, 0, 1);

        // R2 random stretch
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] rs, rc, rd;
            logic [1:0] ra;
            rs = $urandom() & $urandom();
            rc = $urandom() & $urandom();
            rd = $urandom();
            ra = $urandom();
            cyc("R2 random", rs, rc, ($urandom() % 3) == 0, ra, rd, ($urandom() % 4) == 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule